// File: doc/BRIEF.md
# Vector Branch Condition Evaluator

This block decides whether a vectorised conditional branch is taken. A caller pulses `start` with a vector length, a flat bank of 4-bit condition fields, a per-element predicate mask, a 5-bit bit selector, two branch-option bits and a set of mode flags. The block copies these inputs into registers and then walks the elements in increasing index order, one element per clock. Each element tests one bit of one condition field. The walk stops as soon as the outcome is settled.

Two combining modes are available. In all-mode, every tested element must pass, and the first failure ends the walk with the branch not taken. In any-mode, a single passing element is enough, and the first pass ends the walk with the branch taken. Predication can act on an element in three ways. A masked-out element is skipped when zero substitution is off. When zero substitution is on, its test bit is replaced by a forced constant. When the vector-length-set flag is on, an early exit also yields a truncated vector length.

When the walk ends, the block pulses `done`. It then holds the outcome, the resulting vector length with its valid flag, and the count of unmasked elements actually tested. The caller uses that count to decrement its own loop counter.

Top module: `vbc_eval`

## Requirements
- R1: Element i tests bit b = `bit_sel[1:0]` of field f = (`bit_sel[4:2]` + i) mod NFIELD. Field f occupies `cond_fields[4f+3:4f]`, and bit b is `cond_fields[4f+b]`, with b=0 EQ, b=1 LT, b=2 GT and b=3 SO.
- R2: An element passes when `bo_force`=1, or when its test bit equals `bo_sense`.
- R3: With `all_mode`=1 the combined result starts true. The first tested element that fails ends the walk with `taken`=0. If no element fails, `taken`=1.
- R4: With `all_mode`=0 the combined result starts false. The first tested element that passes ends the walk with `taken`=1. If no element passes, `taken`=0.
- R5: After `start` is accepted, one element is evaluated per clock, in increasing index order. `done` goes high for exactly one cycle. It rises two negedges after the start edge when the walk exits at element 0, i+2 negedges when it exits at element i, and len+1 negedges when the walk runs to the end.
- R6: An element with predicate bit 0 and `zero_sub`=0 is skipped. It can neither end the walk nor change the result.
- R7: An element with predicate bit 0 and `zero_sub`=1 is tested with its test bit replaced by `sub_one`.
- R8: When `vl_set`=1 and the walk exits early at element i, `new_vl` is i+1 if `vl_incl`=1 and i if `vl_incl`=0, and `new_vl_valid`=1. In every other case `new_vl` equals the clamped vector length and `new_vl_valid`=0.
- R9: `tested_cnt` equals the number of elements with predicate bit 1 that were reached, counting up to and including the exit element.
- R10: A vector length of 0 gives `done` at the first negedge after the start edge, with `taken`=`all_mode`, `tested_cnt`=0 and `new_vl_valid`=0.
- R11: `start` is ignored while a walk is running. A vector length above MAXVL is treated as MAXVL.
- R12: After reset, `done`, `taken`, `new_vl`, `new_vl_valid` and `tested_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| vl | input | VLW | Vector length; values above MAXVL are clamped |
| cond_fields | input | 4*NFIELD | Condition fields; field f at [4f+3:4f] |
| pred_mask | input | MAXVL | Predicate bit per element |
| bit_sel | input | 5 | [4:2] base field, [1:0] bit within field |
| bo_force | input | 1 | Force every tested element to pass |
| bo_sense | input | 1 | Value the test bit must equal to pass |
| all_mode | input | 1 | 1: all must pass, 0: any passes |
| zero_sub | input | 1 | Substitute a constant for masked elements |
| sub_one | input | 1 | Value of the substituted test bit |
| vl_set | input | 1 | Truncate the vector length at the exit element |
| vl_incl | input | 1 | Include the exit element in the truncated length |
| done | output | 1 | One-cycle completion strobe |
| taken | output | 1 | Branch outcome |
| new_vl | output | VLW | Resulting vector length |
| new_vl_valid | output | 1 | new_vl was truncated by an early exit |
| tested_cnt | output | VLW | Unmasked elements tested |

## Verification
The bound checker watches the per-cycle rules on every cycle:
- `done` lasts exactly one cycle and never coincides with a running walk.
- The element index advances by one on every non-final step.
- A skipped element never causes an exit.
- An exit in all-mode always reports not taken, and an exit in any-mode always reports taken.
- The running count never exceeds the index.
- A `start` pulse during a walk leaves the latched length alone.
- A truncated length is only reported when truncation was requested, and it never exceeds the clamped length.

The things only the bench's scenarios can show are checked against a reference model of the element walk:
- which field and bit each element actually reads;
- the pass rule under each `bo_force`/`bo_sense` setting;
- the exact exit element, and therefore the latency;
- the truncated length for both settings of `vl_incl`;
- the final tested count.

// File: rtl/vbc_pkg.sv
`timescale 1ns/1ps
package vbc_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} vbc_state_e;

  // Pass rule for one element.
  function automatic logic elem_pass(input logic test_bit, input logic force_pass,
                                     input logic sense);
    return force_pass | ~(test_bit ^ sense);
  endfunction

  // An element settles the outcome when it fails in all-mode or passes in any-mode.
  function automatic logic settles(input logic all_m, input logic pass);
    return all_m ? ~pass : pass;
  endfunction

  // Combine one element result into the running value.
  function automatic logic combine(input logic all_m, input logic acc, input logic pass);
    return all_m ? (acc & pass) : (acc | pass);
  endfunction

  // Length after truncation at exit element idx.
  function automatic int unsigned trunc_len(input int unsigned idx, input logic incl);
    return incl ? idx + 1 : idx;
  endfunction

  // Field index of element idx relative to base, modulo field count.
  function automatic int unsigned field_of(input int unsigned base, input int unsigned idx,
                                           input int unsigned nfield);
    return (base + idx) % nfield;
  endfunction

endpackage

// File: rtl/vbc_field_mux.sv
`timescale 1ns/1ps
module vbc_field_mux #(
  parameter int NFIELD = 128,
  parameter int VLW    = 7,
  localparam int FW    = $clog2(NFIELD)
) (
  input  logic [4*NFIELD-1:0] fields,
  input  logic [2:0]          base_fld,
  input  logic [1:0]          bit_pos,
  input  logic [VLW-1:0]      idx,
  output logic [FW-1:0]       field_idx,
  output logic                raw_bit
);
  import vbc_pkg::*;

  logic [NFIELD-1:0] bit_column;

  // one selected bit per field
  for (genvar g = 0; g < NFIELD; g++) begin : g_col
    logic [3:0] fld;
    assign fld           = fields[g*4 +: 4];
    assign bit_column[g] = fld[bit_pos];
  end

  always_comb begin
    field_idx = FW'(field_of(32'(base_fld), 32'(idx), NFIELD));
    raw_bit   = bit_column[field_idx];
  end

endmodule

// File: rtl/vbc_elem_eval.sv
`timescale 1ns/1ps
module vbc_elem_eval (
  input  logic raw_bit,
  input  logic pred_bit,
  input  logic zero_sub,
  input  logic sub_one,
  input  logic bo_force,
  input  logic bo_sense,
  input  logic all_m,
  output logic el_skip,
  output logic el_counted,
  output logic el_ok,
  output logic el_stop
);
  import vbc_pkg::*;

  logic test_bit;

  always_comb begin
    el_skip    = ~pred_bit & ~zero_sub;
    el_counted = pred_bit;
    test_bit   = pred_bit ? raw_bit : sub_one;
    el_ok      = elem_pass(test_bit, bo_force, bo_sense);
    el_stop    = ~el_skip & settles(all_m, el_ok);
  end

endmodule

// File: rtl/vbc_ctrl.sv
`timescale 1ns/1ps
module vbc_ctrl #(
  parameter int NFIELD = 128,
  parameter int MAXVL  = 64,
  parameter int VLW    = 7,
  localparam int IW    = $clog2(MAXVL)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [VLW-1:0]      vl,
  input  logic [4*NFIELD-1:0] cond_fields,
  input  logic [MAXVL-1:0]    pred_mask,
  input  logic [4:0]          bit_sel,
  input  logic                bo_force,
  input  logic                bo_sense,
  input  logic                all_mode,
  input  logic                zero_sub,
  input  logic                sub_one,
  input  logic                vl_set,
  input  logic                vl_incl,
  // element evaluation results
  input  logic                el_skip,
  input  logic                el_counted,
  input  logic                el_ok,
  input  logic                el_stop,
  // latched configuration toward the element path
  output logic [4*NFIELD-1:0] fields_q,
  output logic [4:0]          sel_q,
  output logic                pred_bit,
  output logic                bo0_q,
  output logic                bo1_q,
  output logic                all_q,
  output logic                sz_q,
  output logic                snz_q,
  output logic                vlset_q,
  // observation
  output logic                busy,
  output logic [VLW-1:0]      cur_idx,
  output logic [VLW-1:0]      len_q,
  output logic [VLW-1:0]      run_cnt,
  output logic                exit_hit,
  output logic                last_elem,
  // results
  output logic                done,
  output logic                taken,
  output logic [VLW-1:0]      new_vl,
  output logic                new_vl_valid,
  output logic [VLW-1:0]      tested_cnt
);
  import vbc_pkg::*;

  vbc_state_e         state;
  logic [MAXVL-1:0]   pred_q;
  logic               vli_q;
  logic               comb_q;
  logic               comb_next;
  logic [VLW-1:0]     step_cnt;
  logic [VLW-1:0]     len_in;
  logic [VLW-1:0]     trunc_vl;

  function automatic logic [VLW-1:0] clamp_len(input logic [VLW-1:0] v);
    return (32'(v) > MAXVL) ? VLW'(MAXVL) : v;
  endfunction

  always_comb begin
    busy      = (state == ST_RUN);
    len_in    = clamp_len(vl);
    pred_bit  = pred_q[IW'(cur_idx)];
    last_elem = (cur_idx == len_q - VLW'(1));
    exit_hit  = busy & el_stop;
    comb_next = el_skip ? comb_q : combine(all_q, comb_q, el_ok);
    step_cnt  = run_cnt + (el_counted ? VLW'(1) : VLW'(0));
    trunc_vl  = VLW'(trunc_len(32'(cur_idx), vli_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      fields_q     <= '0;
      sel_q        <= '0;
      pred_q       <= '0;
      bo0_q        <= 1'b0;
      bo1_q        <= 1'b0;
      all_q        <= 1'b0;
      sz_q         <= 1'b0;
      snz_q        <= 1'b0;
      vlset_q      <= 1'b0;
      vli_q        <= 1'b0;
      cur_idx      <= '0;
      len_q        <= '0;
      run_cnt      <= '0;
      comb_q       <= 1'b0;
      done         <= 1'b0;
      taken        <= 1'b0;
      new_vl       <= '0;
      new_vl_valid <= 1'b0;
      tested_cnt   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            fields_q     <= cond_fields;
            sel_q        <= bit_sel;
            pred_q       <= pred_mask;
            bo0_q        <= bo_force;
            bo1_q        <= bo_sense;
            all_q        <= all_mode;
            sz_q         <= zero_sub;
            snz_q        <= sub_one;
            vlset_q      <= vl_set;
            vli_q        <= vl_incl;
            len_q        <= len_in;
            cur_idx      <= '0;
            run_cnt      <= '0;
            comb_q       <= all_mode;
            taken        <= 1'b0;
            new_vl       <= '0;
            new_vl_valid <= 1'b0;
            tested_cnt   <= '0;
            if (len_in == '0) begin
              done  <= 1'b1;
              taken <= all_mode;
            end else begin
              state <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          run_cnt <= step_cnt;
          comb_q  <= comb_next;
          if (exit_hit) begin
            done         <= 1'b1;
            taken        <= comb_next;
            new_vl       <= vlset_q ? trunc_vl : len_q;
            new_vl_valid <= vlset_q;
            tested_cnt   <= step_cnt;
            state        <= ST_IDLE;
          end else if (last_elem) begin
            done         <= 1'b1;
            taken        <= comb_next;
            new_vl       <= len_q;
            new_vl_valid <= 1'b0;
            tested_cnt   <= step_cnt;
            state        <= ST_IDLE;
          end else begin
            cur_idx <= cur_idx + VLW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vbc_eval.sv
`timescale 1ns/1ps
module vbc_eval #(
  parameter int NFIELD = 128,
  parameter int MAXVL  = 64,
  localparam int VLW   = $clog2(MAXVL + 1),
  localparam int FW    = $clog2(NFIELD)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [VLW-1:0]      vl,
  input  logic [4*NFIELD-1:0] cond_fields,
  input  logic [MAXVL-1:0]    pred_mask,
  input  logic [4:0]          bit_sel,
  input  logic                bo_force,
  input  logic                bo_sense,
  input  logic                all_mode,
  input  logic                zero_sub,
  input  logic                sub_one,
  input  logic                vl_set,
  input  logic                vl_incl,
  output logic                done,
  output logic                taken,
  output logic [VLW-1:0]      new_vl,
  output logic                new_vl_valid,
  output logic [VLW-1:0]      tested_cnt
);

  logic [4*NFIELD-1:0] fields_q;
  logic [4:0]          sel_q;
  logic                pred_bit;
  logic                bo0_q, bo1_q, all_q, sz_q, snz_q, vlset_q;
  logic                busy;
  logic [VLW-1:0]      cur_idx, len_q, run_cnt;
  logic                exit_hit, last_elem;
  logic                el_skip, el_counted, el_ok, el_stop;
  logic                raw_bit;
  logic [FW-1:0]       field_idx;

  vbc_ctrl #(.NFIELD(NFIELD), .MAXVL(MAXVL), .VLW(VLW)) u_ctrl (
    .clk, .rst_n, .start, .vl, .cond_fields, .pred_mask, .bit_sel,
    .bo_force, .bo_sense, .all_mode, .zero_sub, .sub_one, .vl_set, .vl_incl,
    .el_skip, .el_counted, .el_ok, .el_stop,
    .fields_q, .sel_q, .pred_bit, .bo0_q, .bo1_q, .all_q, .sz_q, .snz_q, .vlset_q,
    .busy, .cur_idx, .len_q, .run_cnt, .exit_hit, .last_elem,
    .done, .taken, .new_vl, .new_vl_valid, .tested_cnt
  );

  vbc_field_mux #(.NFIELD(NFIELD), .VLW(VLW)) u_mux (
    .fields    (fields_q),
    .base_fld  (sel_q[4:2]),
    .bit_pos   (sel_q[1:0]),
    .idx       (cur_idx),
    .field_idx (field_idx),
    .raw_bit   (raw_bit)
  );

  vbc_elem_eval u_elem (
    .raw_bit, .pred_bit,
    .zero_sub (sz_q),
    .sub_one  (snz_q),
    .bo_force (bo0_q),
    .bo_sense (bo1_q),
    .all_m    (all_q),
    .el_skip, .el_counted, .el_ok, .el_stop
  );

endmodule

// File: rtl/vbc_eval_chk.sv
`timescale 1ns/1ps
module vbc_eval_chk #(
  parameter int VLW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           taken,
  input logic           new_vl_valid,
  input logic [VLW-1:0] new_vl,
  input logic [VLW-1:0] cur_idx,
  input logic [VLW-1:0] len_q,
  input logic [VLW-1:0] run_cnt,
  input logic           el_skip,
  input logic           exit_hit,
  input logic           last_elem,
  input logic           all_q,
  input logic           vlset_q
);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !exit_hit && !last_elem) |=> (busy && cur_idx == $past(cur_idx) + VLW'(1)));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  skip_no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && el_skip) |-> !exit_hit);

  // R3
  all_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_hit && all_q) |=> (done && !taken));

  // R4
  any_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_hit && !all_q) |=> (done && taken));

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt <= cur_idx));

  // R8
  vl_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_vl_valid |-> (vlset_q && new_vl <= len_q));

  // R11
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(len_q));

endmodule

bind vbc_eval vbc_eval_chk #(.VLW(VLW)) u_vbc_chk (
  .clk, .rst_n, .start, .busy, .done, .taken, .new_vl_valid, .new_vl,
  .cur_idx, .len_q, .run_cnt, .el_skip, .exit_hit, .last_elem, .all_q, .vlset_q
);

// File: tb/test_vbc_eval.sv
`timescale 1ns/1ps
module test_vbc_eval;
  localparam int NFIELD = 128;
  localparam int MAXVL  = 64;
  localparam int VLW    = $clog2(MAXVL + 1);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic [VLW-1:0]      vl = '0;
  logic [4*NFIELD-1:0] flds = '0;
  logic [MAXVL-1:0]    pred = '0;
  logic [4:0]          sel = '0;
  logic                bo0 = 0, bo1 = 0, allm = 0, sz = 0, snz = 0, vs = 0, vli = 0;
  logic                done, taken, new_vl_valid;
  logic [VLW-1:0]      new_vl, tested_cnt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vbc_eval #(.NFIELD(NFIELD), .MAXVL(MAXVL)) i_vbc_eval (
    .clk, .rst_n, .start, .vl, .cond_fields(flds), .pred_mask(pred), .bit_sel(sel),
    .bo_force(bo0), .bo_sense(bo1), .all_mode(allm), .zero_sub(sz), .sub_one(snz),
    .vl_set(vs), .vl_incl(vli), .done, .taken, .new_vl, .new_vl_valid, .tested_cnt
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Reference: scan elements, find the first settling one.
  task automatic model(output int e_taken, output int e_nvl, output int e_valid,
                       output int e_cnt, output int e_lat);
    int len;
    int ex;
    len = (int'(vl) > MAXVL) ? MAXVL : int'(vl);
    ex = -1;
    e_cnt = 0;
    for (int i = 0; i < len && ex < 0; i++) begin
      int f;
      bit tb, pass;
      f = (int'(sel[4:2]) + i) % NFIELD;
      if (!pred[i] && !sz) continue;
      tb = pred[i] ? flds[f*4 + int'(sel[1:0])] : snz;
      pass = bo0 || (tb == bo1);
      if (pred[i]) e_cnt++;
      if (allm ? !pass : pass) ex = i;
    end
    if (ex >= 0) begin
      e_taken = allm ? 0 : 1;
      e_valid = vs;
      e_nvl   = vs ? (vli ? ex + 1 : ex) : len;
      e_lat   = ex + 2;
    end else begin
      e_taken = allm;
      e_valid = 0;
      e_nvl   = len;
      e_lat   = (len == 0) ? 1 : len + 1;
    end
  endtask

  task automatic run_case(input string tag, input bit hold_start);
    int et, en, ev, ec, el, n;
    bit seen;
    model(et, en, ev, ec, el);
    @(negedge clk);
    start = 1'b1;
    n = 0;
    seen = 0;
    while (!seen && n < 200) begin
      @(negedge clk);
      n++;
      if (!hold_start) start = 1'b0;
      if (done) begin
        seen = 1;
        start = 1'b0;
      end
    end
    chk(seen, {tag, " R5 done seen"}, seen, 1);
    chk(n == el, {tag, " R5 latency"}, n, el);
    chk(int'(taken) == et, {tag, allm ? " R3 taken" : " R4 taken"}, taken, et);
    chk(int'(new_vl) == en, {tag, " R8 new_vl"}, new_vl, en);
    chk(int'(new_vl_valid) == ev, {tag, " R8 valid"}, new_vl_valid, ev);
    chk(int'(tested_cnt) == ec, {tag, " R9 count"}, tested_cnt, ec);
    @(negedge clk);
    chk(!done, {tag, " R5 one-cycle done"}, done, 0);
  endtask

  task automatic set_mode(input bit a, input bit z, input bit s, input bit f,
                          input bit q, input bit v, input bit i);
    allm = a; sz = z; snz = s; bo0 = f; bo1 = q; vs = v; vli = i;
  endtask

  task automatic rand_fields();
    for (int k = 0; k < 4*NFIELD/32; k++) flds[k*32 +: 32] = $urandom;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7731));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!done && !taken && new_vl == 0 && !new_vl_valid && tested_cnt == 0,
        "R12 reset outputs", {done, taken, new_vl_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: only field base+3 bit GT(2) is set; any-mode, sense 1
    flds = '0;
    sel = {3'd5, 2'd2};
    flds[(5+3)*4 + 2] = 1'b1;
    flds[(5+1)*4 + 1] = 1'b1;   // a different bit position must not match
    pred = '1; vl = 8;
    set_mode(0, 0, 0, 0, 1, 1, 1);
    run_case("R1 bit select", 0);

    // R2: sense 0, all fields ones except one bit at element 2 -> pass there
    flds = '1;
    sel = {3'd0, 2'd0};
    flds[2*4 + 0] = 1'b0;
    set_mode(0, 0, 0, 0, 0, 1, 0);
    run_case("R2 sense zero", 0);
    // R2: force-pass in all-mode runs to the end
    set_mode(1, 0, 0, 1, 0, 0, 0);
    run_case("R2 force pass", 0);

    // R6: passing element masked out with sz=0 is skipped
    flds = '0;
    sel = {3'd1, 2'd3};
    flds[(1+2)*4 + 3] = 1'b1;
    flds[(1+5)*4 + 3] = 1'b1;
    pred = '1; pred[2] = 1'b0; vl = 10;
    set_mode(0, 0, 0, 0, 1, 1, 1);
    run_case("R6 skip", 0);

    // R7: all-mode, fields all pass, masked element substitutes sub_one
    flds = '1;
    pred = '1; pred[4] = 1'b0; vl = 9;
    set_mode(1, 1, 1, 0, 1, 1, 0);
    run_case("R7 sub one", 0);
    set_mode(1, 1, 0, 0, 1, 1, 0);
    run_case("R7 sub zero", 0);

    // R10: zero length in both modes
    vl = 0;
    set_mode(1, 0, 0, 0, 1, 1, 1);
    run_case("R10 len0 all", 0);
    set_mode(0, 0, 0, 0, 1, 1, 1);
    run_case("R10 len0 any", 0);

    // R11: length above MAXVL clamps; start held high during walk
    flds = '0; pred = '1; vl = VLW'(MAXVL + 5);
    set_mode(0, 0, 0, 0, 1, 0, 0);
    run_case("R11 clamp", 0);
    flds = '1; vl = 12;
    set_mode(1, 0, 0, 0, 1, 1, 1);
    flds[7*4 + 0] = 1'b0;
    sel = '0;
    run_case("R11 start ignored", 1);

    // R8: truncation both ways at a known element
    flds = '1; flds[3*4 + 1] = 1'b0; sel = {3'd0, 2'd1}; vl = 10; pred = '1;
    set_mode(1, 0, 0, 0, 1, 1, 1);
    run_case("R8 incl", 0);
    set_mode(1, 0, 0, 0, 1, 1, 0);
    run_case("R8 excl", 0);

    // random mix (R3 R4 R6 R7 R8 R9)
    for (int t = 0; t < 300; t++) begin
      rand_fields();
      pred = {$urandom, $urandom};
      if ($urandom % 3 == 0) pred = pred | {$urandom, $urandom};
      sel = 5'($urandom);
      vl  = ($urandom % 10 == 0) ? VLW'($urandom % 80) : VLW'($urandom % 16);
      set_mode(1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4 == 0),
               1'($urandom), 1'($urandom), 1'($urandom));
      run_case("rand", 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule